// File: doc/BRIEF.md
# Memory-Mapped Pin Extender

This block gives a host on a 16-bit memory-mapped bus control of eight general-purpose pins through a single register word. An access selects the block only when the active-low special-function strobe is low and the word address is zero. Writes go to one of two 8-bit registers. Data bit 8 chooses which one: the pin-direction register or the output-drive register. Reads return one word. Its upper byte holds the direction bits. Its lower byte holds, per pin, either the value last written for an output pin or the sampled level of an input pin.

The pads are not modelled. Each pin is brought out as a drive value, an output enable and a separate input, and a pad ring outside the block does the tri-stating. Input levels pass through one capture register on the clock before a read can report them. A read returns its word on the clock after the read is sampled, and the word then holds until the next read.

Top module: `gpx_extender`

## Requirements
- R1: An access takes effect only when `sf_en_ni` is 0 and `addr_i` is 0. A write under any other condition leaves the direction register, the output register, `pin_oe_o` and `pin_out_o` unchanged.
- R2: A write (`rnw_i` = 0) with `wdata_i[8]` = 1 loads `wdata_i[7:0]` into the direction register. Bit n = 1 makes pin n an output, and `pin_oe_o[n]` follows on the next clock.
- R3: A write with `wdata_i[8]` = 0 loads `wdata_i[7:0]` into the output register (1 = on, 0 = off) and leaves the direction register unchanged.
- R4: A read (`rnw_i` = 1) returns the direction register in `rdata_o[15:8]`, so bit n of the word is direction bit n-8.
- R5: For a pin whose direction bit is 1, bit n of `rdata_o` (n = 0..7) is the output-register bit n.
- R6: For a pin whose direction bit is 0, bit n of `rdata_o` is the level of `pin_in_i[n]` captured at the clock edge before the edge that samples the read. A level change in the same cycle as the read is not yet visible.
- R7: `pin_oe_o` equals the direction register. `pin_out_o[n]` equals output-register bit n while direction bit n is 1, and is 0 otherwise.
- R8: Asynchronous reset (`rst_ni` = 0) clears the direction register, the output register and `rdata_o`, so every pin starts as an input with its driver off.
- R9: `rdata_o` changes only on the clock edge that samples a selected read. It holds its value through writes, unselected cycles and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sf_en_ni | input | 1 | Special-function access strobe, active low |
| rnw_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 14 | Word address; only 0 selects the block |
| wdata_i | input | 16 | Write data; bit 8 selects the target register |
| rdata_o | output | 16 | Registered read word {direction, pin status} |
| pin_in_i | input | 8 | Pin input levels from the pads |
| pin_out_o | output | 8 | Pin drive values |
| pin_oe_o | output | 8 | Pin output enables |

## Verification
Two functions can fall in one cycle: a read of the status word and a change of the input pin levels. The bench provokes this by changing `pin_in_i` in the very cycle a read is issued, and by reprogramming the direction register one cycle before a read. It then judges that the read word shows the previously captured level for input pins, and the output-register bit for pins that have just become outputs. A behavioural model that steps once per clock supplies the expected word, drive values and enables, and the bench compares all three on every cycle.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  typedef enum logic {
    TGT_OUT = 1'b0,
    TGT_DIR = 1'b1
  } tgt_e;

  typedef struct packed {
    logic wr;
    logic rd;
    tgt_e tgt;
  } acc_t;
endpackage

// File: rtl/gpx_decode.sv
module gpx_decode
  import gpx_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PIN_W  = 8
) (
  input  logic              sf_en_ni,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tgt_bit_i,
  output acc_t              acc_o
);
  logic sel;

  assign sel       = !sf_en_ni && (addr_i == '0);
  assign acc_o.wr  = sel && !rnw_i;
  assign acc_o.rd  = sel && rnw_i;
  assign acc_o.tgt = tgt_bit_i ? TGT_DIR : TGT_OUT;
endmodule

// File: rtl/gpx_cfg_regs.sv
module gpx_cfg_regs
  import gpx_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_t             acc_i,
  input  logic [PIN_W-1:0] wval_i,
  output logic [PIN_W-1:0] dir_o,
  output logic [PIN_W-1:0] out_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      out_o <= '0;
    end else if (acc_i.wr) begin
      if (acc_i.tgt == TGT_DIR) dir_o <= wval_i;
      else                      out_o <= wval_i;
    end
  end
endmodule

// File: rtl/gpx_rd_path.sv
module gpx_rd_path
  import gpx_pkg::*;
#(
  parameter int PIN_W = 8,
  localparam int WORD_W = 2 * PIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_t              acc_i,
  input  logic [PIN_W-1:0]  pin_in_i,
  input  logic [PIN_W-1:0]  dir_i,
  input  logic [PIN_W-1:0]  out_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [PIN_W-1:0] cap_q;
  logic [PIN_W-1:0] status;

  // capture flops carry no reset; they reload every clock
  always_ff @(posedge clk_i) cap_q <= pin_in_i;

  for (genvar n = 0; n < PIN_W; n++) begin : g_pin
    assign status[n] = dir_i[n] ? out_i[n] : cap_q[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_o <= '0;
    else if (acc_i.rd)  rdata_o <= {dir_i, status};
  end
endmodule

// File: rtl/gpx_extender.sv
module gpx_extender
  import gpx_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PIN_W  = 8,
  localparam int DATA_W = 2 * PIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sf_en_ni,
  input  logic              rnw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [PIN_W-1:0]  pin_in_i,
  output logic [PIN_W-1:0]  pin_out_o,
  output logic [PIN_W-1:0]  pin_oe_o
);
  acc_t             acc;
  logic [PIN_W-1:0] dir_q;
  logic [PIN_W-1:0] out_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:PIN_W+1];

  gpx_decode #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_decode (
    .sf_en_ni (sf_en_ni),
    .rnw_i    (rnw_i),
    .addr_i   (addr_i),
    .tgt_bit_i(wdata_i[PIN_W]),
    .acc_o    (acc)
  );

  gpx_cfg_regs #(.PIN_W(PIN_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .acc_i (acc),
    .wval_i(wdata_i[PIN_W-1:0]),
    .dir_o (dir_q),
    .out_o (out_q)
  );

  gpx_rd_path #(.PIN_W(PIN_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .pin_in_i(pin_in_i),
    .dir_i   (dir_q),
    .out_i   (out_q),
    .rdata_o (rdata_o)
  );

  assign pin_oe_o  = dir_q;
  assign pin_out_o = out_q & dir_q;
endmodule

// File: rtl/gpx_extender_chk.sv
module gpx_extender_chk #(
  parameter int ADDR_W = 14,
  parameter int PIN_W  = 8,
  localparam int DATA_W = 2 * PIN_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sf_en_ni,
  input logic              rnw_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [PIN_W-1:0]  pin_in_i,
  input logic [PIN_W-1:0]  pin_out_o,
  input logic [PIN_W-1:0]  pin_oe_o
);
  logic sel_wr, sel_rd;
  assign sel_wr = !sf_en_ni && addr_i == '0 && !rnw_i;
  assign sel_rd = !sf_en_ni && addr_i == '0 && rnw_i;

  assert_unselected_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_en_ni || addr_i != '0) |=> ($stable(pin_oe_o) && $stable(pin_out_o)));

  assert_dir_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr && wdata_i[PIN_W]) |=> (pin_oe_o == $past(wdata_i[PIN_W-1:0])));

  assert_out_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_wr && !wdata_i[PIN_W]) |=>
      ($stable(pin_oe_o) && pin_out_o == ($past(wdata_i[PIN_W-1:0]) & pin_oe_o)));

  assert_dir_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rd |=> (rdata_o[DATA_W-1:PIN_W] == $past(pin_oe_o)));

  assert_out_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rd |=> (((rdata_o[PIN_W-1:0] ^ $past(pin_out_o)) & $past(pin_oe_o)) == '0));

  assert_in_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_rd |=> (((rdata_o[PIN_W-1:0] ^ $past(pin_in_i, 2)) & ~$past(pin_oe_o)) == '0));

  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_rd |=> $stable(rdata_o));
endmodule

bind gpx_extender gpx_extender_chk #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sf_en_ni (sf_en_ni),
  .rnw_i    (rnw_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pin_in_i (pin_in_i),
  .pin_out_o(pin_out_o),
  .pin_oe_o (pin_oe_o)
);

// File: tb/tb_gpx_extender.sv
module tb_gpx_extender;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 14;
  localparam int PIN_W  = 8;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sf_en_n = 1'b1;
  logic              rnw = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [PIN_W-1:0]  pins = '0;
  logic [DATA_W-1:0] rdata;
  logic [PIN_W-1:0]  pin_out, pin_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model state
  logic [DATA_W-1:0] rd_m = '0;
  logic [PIN_W-1:0]  dir_m = '0, out_m = '0, cap_m = '0;

  always #(CLK_P/2) clk = ~clk;

  gpx_extender dut (
    .clk_i(clk), .rst_ni(rst_n), .sf_en_ni(sf_en_n), .rnw_i(rnw),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pin_in_i(pins), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_m = '0; dir_m = '0; out_m = '0;
    end else if (!sf_en_n && addr == 0) begin
      if (rnw) begin
        for (int n = 0; n < PIN_W; n++)
          rd_m[n] = dir_m[n] ? out_m[n] : cap_m[n];
        rd_m[DATA_W-1:PIN_W] = dir_m;
      end else if (wdata[8]) dir_m = wdata[7:0];
      else out_m = wdata[7:0];
    end
    cap_m = pins;
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "rdata", 32'(rdata), 32'(rd_m));
    chk(tag, "pin_oe", 32'(pin_oe), 32'(dir_m));
    chk(tag, "pin_out", 32'(pin_out), 32'(out_m & dir_m));
  endtask

  task automatic step(string tag, logic sf, logic r, logic [ADDR_W-1:0] a,
                      logic [DATA_W-1:0] d, logic [PIN_W-1:0] p);
    sf_en_n = sf; rnw = r; addr = a; wdata = d; pins = p;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R8");
    rst_n = 1'b1;
    step("R8", 1, 1, 0, 16'h0000, 8'h3C);
    // output register written while all pins are inputs: no drive
    step("R3", 0, 0, 0, 16'h00A5, 8'h3C);
    step("R7", 1, 1, 0, 16'h0000, 8'h3C);
    // direction write, low nibble outputs
    step("R2", 0, 0, 0, 16'h010F, 8'h3C);
    step("R7", 1, 1, 0, 16'h0000, 8'h3C);
    // read: upper = dir, outputs show out reg, inputs show captured 3C
    step("R4", 0, 1, 0, 16'h0000, 8'h3C);
    step("R5", 1, 1, 0, 16'h0000, 8'h3C);
    // pins change in the read cycle: old captured value expected
    step("R6", 0, 1, 0, 16'h0000, 8'hC3);
    step("R6", 0, 1, 0, 16'h0000, 8'hC3);
    // ignored accesses: strobe high, nonzero address
    step("R1", 1, 0, 0, 16'h01FF, 8'hC3);
    step("R1", 0, 0, 1, 16'h01F0, 8'hC3);
    step("R1", 0, 0, 14'h2000, 16'h0055, 8'hC3);
    step("R1", 0, 1, 0, 16'h0000, 8'hC3);
    // upper data bits do not alter target selection
    step("R3", 0, 0, 0, 16'hFE5A, 8'h00);
    step("R9", 1, 0, 0, 16'h0000, 8'hFF);
    step("R9", 0, 1, 3, 16'h0000, 8'h81);
    // direction flip just before a read
    step("R2", 0, 0, 0, 16'h01F0, 8'h81);
    step("R5", 0, 1, 0, 16'h0000, 8'h18);
    step("R6", 0, 1, 0, 16'h0000, 8'h18);
    // randomised traffic
    for (int i = 0; i < 400; i++) begin
      logic [DATA_W-1:0] d = DATA_W'($urandom);
      step("R5", 1'($urandom_range(0, 3) == 0), 1'($urandom),
           ($urandom_range(0, 3) == 0) ? ADDR_W'(1) : '0, d, PIN_W'($urandom));
    end
    // async reset mid-run
    #(CLK_P/4) rst_n = 1'b0;
    #1;
    chk("R8", "pin_oe", 32'(pin_oe), 32'h0);
    chk("R8", "rdata", 32'(rdata), 32'h0);
    @(negedge clk);
    compare("R8");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule